// File: doc/BRIEF.md
# Receive Descriptor Scatter Engine

This block takes received Ethernet frames as a byte stream and lays them out in memory through a ring of receive descriptors. While the payload streams in, it computes a CRC-32 over it. It then appends the four CRC bytes and spreads the result over as many buffers as it needs. No buffer gets more bytes than the programmed buffer size. When it closes a buffer, it writes the buffer's length and status back into that buffer's descriptor and raises a per-buffer or per-frame event.

The frame can be shortened at a truncation limit and flagged as long against a separate maximum frame length. An optional pair of zero bytes can go at the head of the first buffer so that the layer-3 header lands on an aligned word.

After each frame, the engine reads the next descriptor to decide whether reception stays active. It drops whole frames while it is inactive. Software restarts it by rewinding the ring pointer and then arming the engine.

Each descriptor is 8 bytes:
- The low 32-bit word holds the length in bits 15:0 and the status in bits 31:16.
- The high word holds the buffer address.
- Status bit positions: empty E=15, wrap W=13, last L=11, long LG=5, truncated TR=0.

Top module: `rx_scatter_engine`

## Requirements
- R1: The stored frame is the payload followed by its CRC-32, most significant byte first. The CRC uses the reflected polynomial 0xEDB88320, starts from all ones, is inverted at the end, and adds 4 to the frame length.
- R2: The effective buffer size is cfg_buf_size with bits 3:0 forced to zero. Every buffer but the last of a frame is filled to exactly that size. Each written length field equals the bytes placed in that buffer, and the CRC may be split across two buffers.
- R3: The engine writes the low word of every descriptor it fills: E is cleared and the other status bits are kept. Only the final descriptor of a frame gets L; writing it pulses evt_frame_done, and every other descriptor write pulses evt_buf_done.
- R4: If payload plus CRC (plus pad) exceeds cfg_trunc_len (at least 8), exactly cfg_trunc_len bytes are stored. These are the leading bytes followed by the 4 CRC bytes of the full payload. The final descriptor gets both TR and LG.
- R5: LG is set on the final descriptor when the stored frame length exceeds cfg_max_frame; a length equal to it leaves LG clear.
- R6: With cfg_pad_en high, two zero bytes precede the payload in the first buffer only and count toward its length.
- R7: After a descriptor is closed, the pointer returns to cfg_ring_base if that descriptor had W, and otherwise advances by 8.
- R8: Reaching a descriptor whose E is clear in the middle of a frame discards the rest of the frame. It leaves that descriptor untouched, gives no frame event, keeps the pointer on it and clears rx_active.
- R9: After each completed frame, rx_active takes the E bit of the next descriptor. The arm pulse sets rx_active from the current descriptor's E. The rewind pulse loads the pointer from cfg_ring_base and clears rx_active. All of these apply between frames; after reset rx_active is 0.
- R10: A frame arriving while rx_active is low is accepted and discarded, with no memory writes and no events.
- R11: Bytes move only on cycles where s_tvalid and s_tready are both high. s_tready is low between frames and while the engine fetches or closes descriptors, writes pad bytes or writes CRC bytes. A sender may insert idle cycles freely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| s_tdata | input | 8 | Frame byte |
| s_tvalid | input | 1 | Byte valid |
| s_tlast | input | 1 | Final payload byte of the frame |
| s_tready | output | 1 | Engine accepts the byte this cycle |
| cfg_ring_base | input | AW | Address of the first descriptor |
| cfg_buf_size | input | LW | Buffer size; bits 3:0 ignored |
| cfg_trunc_len | input | LW | Truncation limit in bytes |
| cfg_max_frame | input | FLW | Long-frame threshold in bytes |
| cfg_pad_en | input | 1 | Insert two zero bytes before the payload |
| ring_rewind | input | 1 | Pulse: pointer to ring base, reception off |
| arm | input | 1 | Pulse: enable if current descriptor is empty |
| desc_rd_en | output | 1 | Descriptor read request |
| desc_rd_addr | output | AW | Descriptor address |
| desc_rd_data | input | AW+16 | {buffer address, status}, valid the cycle after the request |
| desc_wr_en | output | 1 | Write descriptor low word |
| desc_wr_addr | output | AW | Descriptor address |
| desc_wr_data | output | 32 | {status, length} |
| buf_wr_en | output | 1 | Byte write into a buffer |
| buf_wr_addr | output | AW | Byte address |
| buf_wr_data | output | 8 | Byte value |
| rx_active | output | 1 | Next descriptor is free; frames are accepted |
| evt_buf_done | output | 1 | Pulse: non-final buffer closed |
| evt_frame_done | output | 1 | Pulse: final buffer of a frame closed |

## Verification
The engine is driven with payload lengths that fit one buffer, that span three buffers, and that end so the CRC straddles a buffer boundary. These cases separate the buffer-full split from the CRC placement. Frames at and one step past the truncation limit and the long-frame threshold separate the two length checks. Frames with pad enabled show that the zero bytes reach the first buffer only. Ring layouts with a wrapped descriptor and with a non-empty descriptor in the middle separate the pointer return, early loss and the end-of-frame rx_active decision. A paced input stream and a frame sent while inactive show that throughput gaps change nothing and that dropped frames leave memory untouched.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int DESC_BYTES = 8;
  // status half-word bit positions
  localparam int ST_E  = 15;
  localparam int ST_W  = 13;
  localparam int ST_L  = 11;
  localparam int ST_LG = 5;
  localparam int ST_TR = 0;
  localparam int CRC_BYTES = 4;
  localparam int PAD_BYTES = 2;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_CAPT, S_PAD, S_DATA, S_CRC,
    S_CLOSE, S_CHECK, S_CHECK2, S_DRAIN, S_DROP
  } rxs_state_e;
endpackage

// File: rtl/rxs_crc32.sv
module rxs_crc32 #(
  parameter logic [31:0] POLY = 32'hEDB88320
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_out
);
  logic [31:0] crc_q, crc_nxt;

  always_comb begin
    crc_nxt = crc_q;
    for (int b = 0; b < 8; b++) begin
      if (crc_nxt[0] ^ din[b]) crc_nxt = (crc_nxt >> 1) ^ POLY;
      else                     crc_nxt = crc_nxt >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '1;
    else if (clear)  crc_q <= '1;
    else if (en)     crc_q <= crc_nxt;
  end

  assign crc_out = ~crc_q;
endmodule

// File: rtl/rxs_ring_ptr.sv
module rxs_ring_ptr #(
  parameter int AW = 32,
  parameter int STRIDE = rxs_pkg::DESC_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_base,
  input  logic          advance,
  input  logic          wrap,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] STEP = AW'(STRIDE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr <= '0;
    else if (load_base) ptr <= base;
    else if (advance)   ptr <= wrap ? base : ptr + STEP;
  end
endmodule

// File: rtl/rxs_fill_track.sv
module rxs_fill_track #(
  parameter int LW  = 14,
  parameter int FLW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_frame,
  input  logic           clr_buf,
  input  logic           step,
  input  logic [LW-1:0]  buf_size,
  output logic [LW-1:0]  off,
  output logic [FLW-1:0] pos,
  output logic           last_slot
);
  localparam logic [LW-1:0] ONE = LW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off <= '0;
      pos <= '0;
    end else begin
      if (clr_frame) pos <= '0;
      else if (step) pos <= pos + FLW'(1);
      if (clr_frame || clr_buf) off <= '0;
      else if (step)            off <= off + ONE;
    end
  end

  assign last_slot = (off == buf_size - ONE);
endmodule

// File: rtl/rx_scatter_engine.sv
module rx_scatter_engine #(
  parameter int AW  = 32,
  parameter int LW  = 14,
  parameter int FLW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [7:0]     s_tdata,
  input  logic           s_tvalid,
  input  logic           s_tlast,
  output logic           s_tready,
  input  logic [AW-1:0]  cfg_ring_base,
  input  logic [LW-1:0]  cfg_buf_size,
  input  logic [LW-1:0]  cfg_trunc_len,
  input  logic [FLW-1:0] cfg_max_frame,
  input  logic           cfg_pad_en,
  input  logic           ring_rewind,
  input  logic           arm,
  output logic           desc_rd_en,
  output logic [AW-1:0]  desc_rd_addr,
  input  logic [AW+15:0] desc_rd_data,
  output logic           desc_wr_en,
  output logic [AW-1:0]  desc_wr_addr,
  output logic [31:0]    desc_wr_data,
  output logic           buf_wr_en,
  output logic [AW-1:0]  buf_wr_addr,
  output logic [7:0]     buf_wr_data,
  output logic           rx_active,
  output logic           evt_buf_done,
  output logic           evt_frame_done
);
  import rxs_pkg::*;

  localparam logic [LW-1:0]  SIZE_MASK = ~LW'(15);
  localparam logic [FLW-1:0] CRC_LEN   = FLW'(CRC_BYTES);

  rxs_state_e state, nxt;

  logic [LW-1:0]  buf_size_eff;
  logic [FLW-1:0] keep_lim;
  logic [AW-1:0]  ptr, buf_addr_q;
  logic [15:0]    status_q, status_new;
  logic [1:0]     pad_left, crc_idx;
  logic           payload_done, trunc_q, close_last, active_q;
  logic [LW-1:0]  off;
  logic [FLW-1:0] pos;
  logic           last_slot;
  logic [31:0]    crc_val;
  logic           hs, keep_ok, rd_empty, long_flag, start_frame;
  logic           step, clr_buf, ptr_load, ptr_adv, crc_en;

  assign buf_size_eff = cfg_buf_size & SIZE_MASK;
  assign keep_lim     = FLW'(cfg_trunc_len) - CRC_LEN;
  assign hs           = s_tvalid && s_tready;
  assign keep_ok      = pos < keep_lim;
  assign rd_empty     = desc_rd_data[ST_E];
  assign long_flag    = trunc_q || (pos > cfg_max_frame);
  assign start_frame  = (state == S_IDLE) && !ring_rewind && !(arm && !active_q)
                        && s_tvalid && active_q;

  rxs_crc32 u_crc (
    .clk(clk), .rst_n(rst_n), .clear(start_frame), .en(crc_en),
    .din(s_tdata), .crc_out(crc_val)
  );

  rxs_ring_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load_base(ptr_load), .advance(ptr_adv),
    .wrap(status_q[ST_W]), .base(cfg_ring_base), .ptr(ptr)
  );

  rxs_fill_track #(.LW(LW), .FLW(FLW)) u_fill (
    .clk(clk), .rst_n(rst_n), .clr_frame(start_frame), .clr_buf(clr_buf),
    .step(step), .buf_size(buf_size_eff), .off(off), .pos(pos),
    .last_slot(last_slot)
  );

  // status written back when a descriptor is closed
  always_comb begin
    status_new = status_q;
    status_new[ST_E] = 1'b0;
    if (close_last) begin
      status_new[ST_L] = 1'b1;
      if (trunc_q)   status_new[ST_TR] = 1'b1;
      if (long_flag) status_new[ST_LG] = 1'b1;
    end
  end

  always_comb begin
    nxt            = state;
    s_tready       = 1'b0;
    desc_rd_en     = 1'b0;
    desc_rd_addr   = ptr;
    desc_wr_en     = 1'b0;
    desc_wr_addr   = ptr;
    desc_wr_data   = {status_new, 16'(off)};
    buf_wr_en      = 1'b0;
    buf_wr_addr    = buf_addr_q + AW'(off);
    buf_wr_data    = 8'h00;
    step           = 1'b0;
    clr_buf        = 1'b0;
    ptr_load       = 1'b0;
    ptr_adv        = 1'b0;
    crc_en         = 1'b0;
    evt_buf_done   = 1'b0;
    evt_frame_done = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (ring_rewind)             ptr_load = 1'b1;
        else if (arm && !active_q)   nxt = S_CHECK;
        else if (s_tvalid)           nxt = active_q ? S_FETCH : S_DROP;
      end
      S_FETCH: begin
        desc_rd_en = 1'b1;
        nxt = S_CAPT;
      end
      S_CAPT: begin
        if (!rd_empty) begin
          nxt = payload_done ? S_IDLE : S_DRAIN;
        end else begin
          clr_buf = 1'b1;
          if (pad_left != 2'd0) nxt = S_PAD;
          else if (payload_done) nxt = S_CRC;
          else nxt = S_DATA;
        end
      end
      S_PAD: begin
        buf_wr_en = 1'b1;
        step = 1'b1;
        if (pad_left == 2'd1) nxt = S_DATA;
      end
      S_DATA: begin
        s_tready = 1'b1;
        if (hs) begin
          crc_en = 1'b1;
          if (keep_ok) begin
            buf_wr_en   = 1'b1;
            buf_wr_data = s_tdata;
            step        = 1'b1;
          end
          if (keep_ok && last_slot) nxt = S_CLOSE;
          else if (s_tlast)         nxt = S_CRC;
        end
      end
      S_CRC: begin
        buf_wr_en   = 1'b1;
        buf_wr_data = crc_val[31 - 8*crc_idx -: 8];
        step        = 1'b1;
        if (crc_idx == 2'd3 || last_slot) nxt = S_CLOSE;
      end
      S_CLOSE: begin
        desc_wr_en = 1'b1;
        ptr_adv    = 1'b1;
        if (close_last) begin
          evt_frame_done = 1'b1;
          nxt = S_CHECK;
        end else begin
          evt_buf_done = 1'b1;
          nxt = S_FETCH;
        end
      end
      S_CHECK: begin
        desc_rd_en = 1'b1;
        nxt = S_CHECK2;
      end
      S_CHECK2: nxt = S_IDLE;
      S_DRAIN, S_DROP: begin
        s_tready = 1'b1;
        if (hs && s_tlast) nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      active_q     <= 1'b0;
      buf_addr_q   <= '0;
      status_q     <= '0;
      pad_left     <= '0;
      crc_idx      <= '0;
      payload_done <= 1'b0;
      trunc_q      <= 1'b0;
      close_last   <= 1'b0;
    end else begin
      state <= nxt;
      unique case (state)
        S_IDLE: begin
          if (ring_rewind) active_q <= 1'b0;
          if (start_frame) begin
            pad_left     <= cfg_pad_en ? 2'(PAD_BYTES) : 2'd0;
            crc_idx      <= '0;
            payload_done <= 1'b0;
            trunc_q      <= 1'b0;
            close_last   <= 1'b0;
          end
        end
        S_CAPT: begin
          if (!rd_empty) begin
            active_q <= 1'b0;
          end else begin
            buf_addr_q <= desc_rd_data[AW+15:16];
            status_q   <= desc_rd_data[15:0];
          end
        end
        S_PAD: pad_left <= pad_left - 2'd1;
        S_DATA: begin
          close_last <= 1'b0;
          if (hs) begin
            if (!keep_ok) trunc_q <= 1'b1;
            if (s_tlast)  payload_done <= 1'b1;
          end
        end
        S_CRC: begin
          crc_idx    <= crc_idx + 2'd1;
          close_last <= (crc_idx == 2'd3);
        end
        S_CHECK2: active_q <= rd_empty;
        default: ;
      endcase
    end
  end

  assign rx_active = active_q;
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker #(
  parameter int LW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_tready,
  input logic          desc_wr_en,
  input logic [31:0]   desc_wr_data,
  input logic          buf_wr_en,
  input logic          evt_buf_done,
  input logic          evt_frame_done,
  input logic [LW-1:0] cfg_buf_size
);
  logic [15:0] size_eff;
  assign size_eff = 16'(cfg_buf_size) & 16'hFFF0;

  assert_e_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_en |-> !desc_wr_data[31]);

  assert_frame_evt_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_frame_done |-> (desc_wr_en && desc_wr_data[27]));

  assert_buf_evt_notlast_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_buf_done |-> (desc_wr_en && !desc_wr_data[27]));

  assert_len_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_en |-> (desc_wr_data[15:0] != 16'd0 && desc_wr_data[15:0] <= size_eff));

  assert_tr_has_lg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_wr_en && desc_wr_data[16]) |-> desc_wr_data[21]);

  assert_no_accept_on_close_R11: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_en |-> !s_tready);

  assert_single_writer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_wr_en && desc_wr_en));
endmodule

bind rx_scatter_engine rxs_checker #(.LW(LW)) u_rxs_checker (
  .clk(clk), .rst_n(rst_n), .s_tready(s_tready), .desc_wr_en(desc_wr_en),
  .desc_wr_data(desc_wr_data), .buf_wr_en(buf_wr_en),
  .evt_buf_done(evt_buf_done), .evt_frame_done(evt_frame_done),
  .cfg_buf_size(cfg_buf_size)
);

// File: tb/tb_rx_scatter_engine.sv
`timescale 1ns/1ps
module tb_rx_scatter_engine;
  localparam int AW = 32;
  localparam int LW = 14;
  localparam int FLW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]     s_tdata = '0;
  logic           s_tvalid = 1'b0, s_tlast = 1'b0, s_tready;
  logic [AW-1:0]  cfg_ring_base = 32'h80;
  logic [LW-1:0]  cfg_buf_size = 14'd16;
  logic [LW-1:0]  cfg_trunc_len = 14'd1518;
  logic [FLW-1:0] cfg_max_frame = 16'd1518;
  logic           cfg_pad_en = 1'b0, ring_rewind = 1'b0, arm = 1'b0;
  logic           desc_rd_en, desc_wr_en, buf_wr_en;
  logic [AW-1:0]  desc_rd_addr, desc_wr_addr, buf_wr_addr;
  logic [AW+15:0] desc_rd_data;
  logic [31:0]    desc_wr_data;
  logic [7:0]     buf_wr_data;
  logic           rx_active, evt_buf_done, evt_frame_done;

  rx_scatter_engine #(.AW(AW), .LW(LW), .FLW(FLW)) dut (.*);

  // memory model: 8 descriptors at 0x80, buffers at 0x400 + 64*i
  logic [63:0] dmem [0:7];
  logic [7:0]  bmem [0:2047];
  logic        tb_ld = 1'b0, tb_fill = 1'b0;
  logic [2:0]  tb_idx = '0;
  logic [63:0] tb_val = '0;
  int n_bufw = 0, n_descw = 0, n_evb = 0, n_evf = 0;

  always @(posedge clk) begin
    if (desc_rd_en) desc_rd_data <= {dmem[desc_rd_addr[5:3]][63:32], dmem[desc_rd_addr[5:3]][31:16]};
    if (desc_wr_en) dmem[desc_wr_addr[5:3]][31:0] <= desc_wr_data;
    if (tb_ld) dmem[tb_idx] <= tb_val;
    if (tb_fill) for (int a = 0; a < 2048; a++) bmem[a] <= 8'hEE;
    if (buf_wr_en) bmem[buf_wr_addr[10:0]] <= buf_wr_data;
    if (buf_wr_en) n_bufw <= n_bufw + 1;
    if (desc_wr_en) n_descw <= n_descw + 1;
    if (evt_buf_done) n_evb <= n_evb + 1;
    if (evt_frame_done) n_evf <= n_evf + 1;
  end

  int n_chk = 0, n_fail = 0, wd_fail = 0;
  bit done = 1'b0;
  int s_bufw, s_descw, s_evb, s_evf;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input int seed, input int i);
    return 8'(seed + i * 13 + (i >> 3));
  endfunction

  function automatic logic [31:0] crc_of(input int seed, input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = pay(seed, i);
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ d[b];
        c = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    end
    return ~c;
  endfunction

  task automatic load_desc(input int idx, input bit empty, input bit wrap, input logic [15:0] len);
    logic [15:0] st = '0;
    st[15] = empty;
    st[13] = wrap;
    @(negedge clk);
    tb_ld = 1'b1; tb_idx = 3'(idx);
    tb_val = {32'(32'h400 + idx * 64), st, len};
    @(negedge clk);
    tb_ld = 1'b0;
  endtask

  task automatic prep(input int ring_n, input int bad);
    @(negedge clk); tb_fill = 1'b1; @(negedge clk); tb_fill = 1'b0;
    for (int i = 0; i < 8; i++)
      load_desc(i, (i < ring_n) && (i != bad), i == ring_n - 1, (i == bad) ? 16'h0055 : 16'h0);
    @(negedge clk); ring_rewind = 1'b1; @(negedge clk); ring_rewind = 1'b0;
    arm = 1'b1; @(negedge clk); arm = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic snap();
    s_bufw = n_bufw; s_descw = n_descw; s_evb = n_evb; s_evf = n_evf;
  endtask

  task automatic send(input int plen, input int seed, input int gap);
    for (int i = 0; i < plen; i++) begin
      s_tdata = pay(seed, i); s_tlast = (i == plen - 1); s_tvalid = 1'b1;
      while (!s_tready) @(negedge clk);
      @(negedge clk);
      if (gap > 0) begin s_tvalid = 1'b0; repeat (gap) @(negedge clk); end
    end
    s_tvalid = 1'b0; s_tlast = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  // compare ring contents against the expected layout; returns buffers used
  task automatic check_frame(input int first, input int ring_n, input int plen, input int seed,
                             input int pad, input int trunc, input int maxf, input int msz,
                             input string req, output int nb);
    logic [7:0] exp [0:255];
    int raw, total, keep;
    bit tr, lg;
    logic [31:0] c = crc_of(seed, plen);
    raw = plen + 4 + pad;
    tr = raw > trunc;
    total = tr ? trunc : raw;
    keep = total - 4;
    lg = tr || (total > maxf);
    for (int i = 0; i < keep; i++) exp[i] = (i < pad) ? 8'h00 : pay(seed, i - pad);
    for (int k = 0; k < 4; k++) exp[keep + k] = c[31 - 8*k -: 8];
    nb = (total + msz - 1) / msz;
    for (int b = 0; b < nb; b++) begin
      int idx = (first + b) % ring_n;
      int blen = (total - b * msz < msz) ? total - b * msz : msz;
      bit last = (b == nb - 1);
      logic [63:0] d = dmem[idx];
      int bad = -1;
      chk(d[15:0] == 16'(blen), "R2", "buffer length", d[15:0], blen);
      chk(d[31] == 1'b0 && d[27] == last, "R3", "E/L bits", {d[31], d[27]}, {1'b0, last});
      if (last) begin
        chk(d[16] == tr, "R4", "TR flag", d[16], tr);
        chk(d[21] == lg, "R5", "LG flag", d[21], lg);
      end
      for (int k = 0; k < blen; k++)
        if (bad < 0 && bmem[d[42:32] + 11'(k)] !== exp[b * msz + k]) bad = k;
      if (bad >= 0) chk(1'b0, req, "buffer byte", bmem[d[42:32] + 11'(bad)], exp[b * msz + bad]);
      else chk(1'b1, req, "buffer bytes", 0, 0);
    end
  endtask

  task automatic frame_case(input int ring_n, input int bad, input int plen, input int seed,
                            input int gap, input int msz, input bit exp_active, input string req);
    int nb;
    prep(ring_n, bad);
    snap();
    send(plen, seed, gap);
    check_frame(0, ring_n, plen, seed, cfg_pad_en ? 2 : 0, cfg_trunc_len, cfg_max_frame, msz, req, nb);
    chk(n_evf - s_evf == 1 && n_evb - s_evb == nb - 1, "R3", "events", n_evb - s_evb, nb - 1);
    chk(rx_active == exp_active, "R9", "rx_active after frame", rx_active, exp_active);
  endtask

  task automatic t_reset();
    chk(rx_active == 1'b0, "R9", "rx_active after reset", rx_active, 0);
    chk(s_tready == 1'b0, "R11", "ready idle", s_tready, 0);
  endtask

  task automatic t_drop();
    @(negedge clk); ring_rewind = 1'b1; @(negedge clk); ring_rewind = 1'b0;
    snap();
    send(12, 1, 0);
    chk(n_bufw == s_bufw && n_descw == s_descw, "R10", "writes while inactive", n_bufw - s_bufw, 0);
    chk(n_evb == s_evb && n_evf == s_evf, "R10", "events while inactive", n_evf - s_evf, 0);
  endtask

  task automatic t_arm();
    prep(4, -1);
    chk(rx_active == 1'b1, "R9", "arm on empty descriptor", rx_active, 1);
  endtask

  task automatic t_single();  frame_case(8, -1, 10, 3, 0, 16, 1'b1, "R1"); endtask
  task automatic t_multi();   frame_case(8, -1, 40, 7, 0, 16, 1'b1, "R2"); endtask
  task automatic t_crcsplit(); frame_case(8, -1, 30, 9, 0, 16, 1'b1, "R1"); endtask

  task automatic t_wrap();
    int nb;
    frame_case(4, -1, 40, 5, 0, 16, 1'b1, "R7");
    load_desc(0, 1'b1, 1'b0, 16'h0);
    load_desc(1, 1'b1, 1'b0, 16'h0);
    snap();
    send(20, 11, 0);
    check_frame(3, 4, 20, 11, 0, cfg_trunc_len, cfg_max_frame, 16, "R7", nb);
    chk(nb == 2 && n_evf - s_evf == 1, "R7", "wrapped frame buffers", nb, 2);
    chk(rx_active == 1'b1, "R9", "active after wrap", rx_active, 1);
  endtask

  task automatic t_pad();
    cfg_pad_en = 1'b1;
    frame_case(8, -1, 20, 13, 0, 16, 1'b1, "R6");
    frame_case(8, -1, 10, 17, 0, 16, 1'b1, "R6");
    cfg_pad_en = 1'b0;
  endtask

  task automatic t_long();
    cfg_max_frame = 16'd20;
    frame_case(8, -1, 20, 19, 0, 16, 1'b1, "R5");
    frame_case(8, -1, 16, 23, 0, 16, 1'b1, "R5");
    cfg_max_frame = 16'd1518;
  endtask

  task automatic t_trunc();
    cfg_trunc_len = 14'd24;
    frame_case(8, -1, 40, 29, 0, 16, 1'b1, "R4");
    frame_case(8, -1, 20, 31, 0, 16, 1'b1, "R4");
    cfg_trunc_len = 14'd1518;
  endtask

  task automatic t_lost();
    prep(8, 1);
    snap();
    send(30, 37, 0);
    chk(dmem[0][15:0] == 16'd16 && dmem[0][31] == 1'b0 && dmem[0][27] == 1'b0, "R8",
        "first descriptor", dmem[0][31:0], 32'h0000_0010);
    chk(dmem[1][31:0] == 32'h0000_0055, "R8", "blocked descriptor untouched", dmem[1][31:0], 32'h55);
    chk(n_evb - s_evb == 1 && n_evf == s_evf, "R8", "events on loss", n_evf - s_evf, 0);
    chk(rx_active == 1'b0, "R8", "rx_active after loss", rx_active, 0);
    snap();
    send(8, 41, 0);
    chk(n_bufw == s_bufw && n_descw == s_descw, "R10", "frame after loss dropped", n_bufw - s_bufw, 0);
  endtask

  task automatic t_mask();
    cfg_buf_size = 14'h1F;
    frame_case(8, -1, 30, 43, 0, 16, 1'b1, "R2");
    cfg_buf_size = 14'd16;
  endtask

  task automatic t_paced();
    cfg_buf_size = 14'd32;
    frame_case(8, -1, 25, 47, 2, 32, 1'b1, "R11");
    cfg_buf_size = 14'd16;
  endtask

  task automatic t_next_busy();
    frame_case(8, 1, 5, 53, 0, 16, 1'b0, "R9");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_drop();
    t_arm();
    t_single();
    t_multi();
    t_crcsplit();
    t_wrap();
    t_pad();
    t_long();
    t_trunc();
    t_lost();
    t_mask();
    t_paced();
    t_next_busy();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      wd_fail = 1;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + wd_fail, n_fail + wd_fail);
      $finish;
    end
  end
endmodule